// File: doc/BRIEF.md
# Console Receive Register Pair

This block is the receive side of a console port, seen by software as two 16-bit registers on a simple strobed bus. One register is the status word, which holds a done flag and an interrupt enable. The other is the data word, which holds the last received character together with its error flags. A byte-wide receiver front end delivers one character, or a line-break indication, per valid beat. The block keeps exactly one character. It raises a level interrupt request when a character is waiting and interrupts are enabled. It can also pulse a halt request to the processor when a break arrives and the system allows halting.

Reading the data word has side effects. The read returns the full 16-bit value, including the error flags. At the clock edge that ends the read, the block clears done and the interrupt, and strips the stored word down to its low byte. Setting the enable while a character is already waiting raises the interrupt at once.

The receive stream uses valid/ready. `rx_ready` is held high at all times, so the front end is never back-pressured. If a new beat arrives while the previous character is unread, the old character is overwritten and the overrun flag records the loss. Bus accesses are single-cycle. `bus_rdata` is combinational from the selected register, and all side effects take place at the clock edge that ends the access.

Top module: `con_rx_regs`

## Requirements
- R1: After reset, both registers read 0, `irq` is low and `halt_req` is low.
- R2: The status word (`bus_sel`=0) reads done in bit 7 and enable in bit 6, with every other bit 0. A write changes only bit 6; done is not affected by any write.
- R3: A beat with `rx_valid` high and `rx_break` low loads the data word with the character zero-extended into bits 7:0 and sets done. `rx_ready` is always high.
- R4: When `seven_bit` is high, bit 7 of a received character is stored as 0. When it is low, all 8 bits are kept.
- R5: A break beat loads the data word with 16'hA400 (bit 15 error, bit 13 framing, bit 10 break). The character lines are ignored, and done is set.
- R6: A break beat accepted while `halt_en` is high makes `halt_req` high for exactly the following cycle. Otherwise `halt_req` stays low.
- R7: A beat accepted while the enable is set raises `irq` in the next cycle. `irq` then stays high until it is cleared by a data-word read, by a status write with bit 6 clear, or by reset.
- R8: A data-word read (`bus_sel`=1) returns the full stored word. Afterwards done and `irq` are 0 and the stored word keeps only bits 7:0.
- R9: A status write with bit 6 clear drops `irq` in the next cycle.
- R10: A status write with bit 6 set, made while done is set and the enable was clear, raises `irq` in the next cycle.
- R11: A beat that arrives while done is set, and that is not in the same cycle as a data-word read, stores the new value with bit 14 (overrun) also set.
- R12: If a beat and a data-word read fall in the same cycle, the read returns the old word. The new character is then stored without overrun, done stays set, and `irq` follows R7.
- R13: Writes to the data-word address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Always high; the block never stalls the receiver |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | The beat carries a line break, not a character |
| seven_bit | input | 1 | Keep only the low 7 bits of characters |
| halt_en | input | 1 | A break may request a processor halt |
| bus_sel | input | 1 | Register select: 0 status, 1 data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Level interrupt request |
| halt_req | output | 1 | One-cycle halt request after a break |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. Under that assumption, a status write and a data-word read cannot coincide, which is why `irq` implies both done and enable. The stimulus drives one bus strobe at a time and holds every input stable across each clock edge. Receive beats are placed next to reads, status writes and other beats, so that the overrun and same-cycle orderings are exercised within that assumption.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned DONE_BIT = 7;
  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned ERR_BIT  = 15;
  localparam int unsigned OVR_BIT  = 14;
  localparam int unsigned FRM_BIT  = 13;
  localparam int unsigned BRK_BIT  = 10;
  localparam int unsigned LOW_W    = 8;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_DATA   = 1'b1
  } reg_sel_e;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/con_rx_format.sv
module con_rx_format
  import con_rx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic [CHAR_W-1:0] char_in,
  input  logic              is_break,
  input  logic              seven_bit,
  input  logic              overrun,
  output word_t             word_out
);
  localparam int unsigned KEEP7 = 7;

  logic [CHAR_W-1:0] masked;

  // bits at or above position 7 are dropped in seven-bit mode
  for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
    if (i >= KEEP7) begin : g_hi
      assign masked[i] = char_in[i] & ~seven_bit;
    end else begin : g_lo
      assign masked[i] = char_in[i];
    end
  end

  always_comb begin
    word_out = '0;
    if (is_break) begin
      word_out[ERR_BIT] = 1'b1;
      word_out[FRM_BIT] = 1'b1;
      word_out[BRK_BIT] = 1'b1;
    end else begin
      word_out[CHAR_W-1:0] = masked;
    end
    word_out[OVR_BIT] = overrun;
  end
endmodule

// File: rtl/con_rx_status.sv
module con_rx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive,
  input  logic rd_data,
  input  logic wr_status,
  input  logic wr_ie,
  output logic done,
  output logic ie,
  output logic irq
);
  logic ie_next;

  assign ie_next = wr_status ? wr_ie : ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      ie   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      ie <= ie_next;
      if (arrive)       done <= 1'b1;
      else if (rd_data) done <= 1'b0;

      if (wr_status && !wr_ie)                    irq <= 1'b0;
      else if (arrive && ie_next)                 irq <= 1'b1;
      else if (wr_status && wr_ie && done && !ie) irq <= 1'b1;
      else if (rd_data)                           irq <= 1'b0;
    end
  end

  // R7
  irq_needs_done_and_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && ie));

  // R9
  ie_clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !wr_ie) |=> !irq);

  // R3
  arrive_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arrive |=> done);

  // R10
  late_enable_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && wr_ie && done && !ie) |=> irq);
endmodule

// File: rtl/con_rx_buffer.sv
module con_rx_buffer
  import con_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_word,
  input  logic  strip,
  output word_t buf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     buf_q <= '0;
    else if (load)  buf_q <= load_word;
    else if (strip) buf_q <= {{(WORD_W-LOW_W){1'b0}}, buf_q[LOW_W-1:0]};
  end

  // R8
  strip_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strip && !load) |=> (buf_q[WORD_W-1:LOW_W] == '0));
endmodule

// File: rtl/con_rx_regs.sv
module con_rx_regs
  import con_rx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_break,
  input  logic              seven_bit,
  input  logic              halt_en,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              halt_req
);
  logic  arrive, rd_data, wr_status, overrun;
  logic  done, ie;
  word_t fmt_word, buf_q, status_word;
  logic  unused_wdata_bits;

  assign rx_ready  = 1'b1;
  assign arrive    = rx_valid;
  assign rd_data   = bus_rd && (bus_sel == SEL_DATA);
  assign wr_status = bus_wr && (bus_sel == SEL_STATUS);
  assign overrun   = done && !rd_data;
  assign unused_wdata_bits = ^{bus_wdata[15:IE_BIT+1], bus_wdata[IE_BIT-1:0]};

  con_rx_format #(.CHAR_W(CHAR_W)) u_format (
    .char_in   (rx_data),
    .is_break  (rx_break),
    .seven_bit (seven_bit),
    .overrun   (overrun),
    .word_out  (fmt_word)
  );

  con_rx_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive    (arrive),
    .rd_data   (rd_data),
    .wr_status (wr_status),
    .wr_ie     (bus_wdata[IE_BIT]),
    .done      (done),
    .ie        (ie),
    .irq       (irq)
  );

  con_rx_buffer u_buffer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (arrive),
    .load_word (fmt_word),
    .strip     (rd_data),
    .buf_q     (buf_q)
  );

  always_comb begin
    status_word           = '0;
    status_word[DONE_BIT] = done;
    status_word[IE_BIT]   = ie;
  end

  assign bus_rdata = (bus_sel == SEL_DATA) ? buf_q : status_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_req <= 1'b0;
    else        halt_req <= arrive && rx_break && halt_en;
  end

  // R6
  break_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break && halt_en) |=> halt_req);

  // R6
  halt_only_on_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_break && halt_en) |=> !halt_req);

  // R11
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && done && !(bus_rd && bus_sel)) |=> bus_sel == SEL_STATUS || buf_q[OVR_BIT]);
endmodule

// File: tb/con_rx_regs_test.sv
module con_rx_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_break = 1'b0, seven_bit = 1'b0, halt_en = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0000;
  logic        rx_ready, irq, halt_req;
  logic [15:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  int m_buf = 0;
  bit m_done = 0, m_ie = 0, m_irq = 0, m_halt = 0;

  always #10 clk = ~clk;

  con_rx_regs uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_break(rx_break), .seven_bit(seven_bit),
    .halt_en(halt_en), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .halt_req(halt_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: advance on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_buf = 0; m_done = 0; m_ie = 0; m_irq = 0; m_halt = 0;
    end else begin
      bit arr, rdb, wrs, nie;
      int w;
      arr = rx_valid;
      rdb = bus_rd && bus_sel;
      wrs = bus_wr && !bus_sel;
      nie = wrs ? bus_wdata[6] : m_ie;
      if (wrs && !bus_wdata[6])                      m_irq = 0;
      else if (arr && nie)                           m_irq = 1;
      else if (wrs && bus_wdata[6] && m_done && !m_ie) m_irq = 1;
      else if (rdb)                                  m_irq = 0;
      if (arr) begin
        if (rx_break) w = 'hA400;
        else w = seven_bit ? (rx_data % 128) : rx_data;
        if (m_done && !rdb) w = w + 'h4000;
        m_buf = w;
        m_done = 1;
      end else if (rdb) begin
        m_buf = m_buf % 256;
        m_done = 0;
      end
      m_ie = nie;
      m_halt = arr && rx_break && halt_en;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_rd;
      exp_rd = bus_sel ? m_buf : ((m_done ? 'h80 : 0) + (m_ie ? 'h40 : 0));
      chk("MODEL rdata R2 R3 R8", bus_rdata, exp_rd);
      chk("MODEL irq R7", irq, m_irq);
      chk("MODEL halt R6", halt_req, m_halt);
      chk("MODEL ready R3", rx_ready, 1);
    end
  end

  task automatic cyc(input bit v, input bit brk, input logic [7:0] d,
                     input bit rd, input bit wr, input bit sel, input logic [15:0] wd);
    @(posedge clk); #2;
    rx_valid = v; rx_break = brk; rx_data = d;
    bus_rd = rd; bus_wr = wr; bus_sel = sel; bus_wdata = wd;
  endtask

  task automatic idle(input bit sel);
    cyc(0, 0, 8'h00, 0, 0, sel, 16'h0000);
  endtask

  task automatic send(input logic [7:0] d, input bit brk);
    cyc(1, brk, d, 0, 0, 0, 16'h0000);
  endtask

  task automatic rd_buf();
    cyc(0, 0, 8'h00, 1, 0, 1, 16'h0000);
  endtask

  task automatic wr_st(input logic [15:0] wd);
    cyc(0, 0, 8'h00, 0, 1, 0, wd);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", bus_rdata, 16'h0000);
    chk("R1 irq", irq, 0);
    chk("R1 halt", halt_req, 0);
    chk("R3 ready", rx_ready, 1);
    idle(1); @(negedge clk);
    chk("R1 data", bus_rdata, 16'h0000);

    // R3 plain character, enable clear
    send(8'h41, 0); idle(1); @(negedge clk);
    chk("R3 data", bus_rdata, 16'h0041);
    chk("R7 no irq when disabled", irq, 0);
    idle(0); @(negedge clk);
    chk("R3 done", bus_rdata, 16'h0080);

    // R10 enable set while done; R2 only bit 6 writable
    wr_st(16'hFFFF); idle(0); @(negedge clk);
    chk("R10 irq", irq, 1);
    chk("R2 status", bus_rdata, 16'h00C0);

    // R8 read side effects
    rd_buf(); @(negedge clk);
    chk("R8 read value", bus_rdata, 16'h0041);
    idle(0); @(negedge clk);
    chk("R8 done cleared", bus_rdata, 16'h0040);
    chk("R8 irq cleared", irq, 0);

    // R7 eight-bit character with enable
    send(8'hC1, 0); idle(1); @(negedge clk);
    chk("R7 irq", irq, 1);
    chk("R4 eight bit", bus_rdata, 16'h00C1);
    idle(1); @(negedge clk);
    chk("R7 irq held", irq, 1);
    rd_buf();

    // R4 seven-bit mode
    seven_bit = 1'b1;
    send(8'hC1, 0); idle(1); @(negedge clk);
    chk("R4 seven bit", bus_rdata, 16'h0041);
    rd_buf(); seven_bit = 1'b0;

    // R11 overrun
    send(8'h31, 0); send(8'h32, 0); idle(1); @(negedge clk);
    chk("R11 overrun", bus_rdata, 16'h4032);
    rd_buf(); @(negedge clk);
    chk("R8 full word", bus_rdata, 16'h4032);
    idle(1); @(negedge clk);
    chk("R8 masked", bus_rdata, 16'h0032);

    // R5/R6 break with halt allowed
    halt_en = 1'b1;
    send(8'h5A, 1); idle(1); @(negedge clk);
    chk("R6 halt pulse", halt_req, 1);
    chk("R5 break word", bus_rdata, 16'hA400);
    idle(1); @(negedge clk);
    chk("R6 halt one cycle", halt_req, 0);
    rd_buf(); idle(1); @(negedge clk);
    chk("R8 break flags removed", bus_rdata, 16'h0000);

    // R6 break with halt not allowed
    halt_en = 1'b0;
    send(8'h00, 1); idle(1); @(negedge clk);
    chk("R6 no halt", halt_req, 0);
    chk("R5 break word again", bus_rdata, 16'hA400);
    rd_buf();

    // R9 enable clear drops irq
    send(8'h10, 0); idle(0); @(negedge clk);
    chk("R9 irq before", irq, 1);
    wr_st(16'h0000); idle(0); @(negedge clk);
    chk("R9 irq dropped", irq, 0);
    chk("R2 done kept", bus_rdata, 16'h0080);

    // R13 write to data address ignored
    cyc(0, 0, 8'h00, 0, 1, 1, 16'hFF55); idle(1); @(negedge clk);
    chk("R13 data unchanged", bus_rdata, 16'h0010);
    idle(0); @(negedge clk);
    chk("R13 status unchanged", bus_rdata, 16'h0080);
    rd_buf();

    // R12 beat and read in the same cycle
    wr_st(16'h0040);
    send(8'h11, 0);
    cyc(1, 0, 8'h22, 1, 0, 1, 16'h0000); @(negedge clk);
    chk("R12 read old", bus_rdata, 16'h0011);
    idle(1); @(negedge clk);
    chk("R12 new no overrun", bus_rdata, 16'h0022);
    chk("R12 irq", irq, 1);
    idle(0); @(negedge clk);
    chk("R12 done", bus_rdata, 16'h00C0);

    idle(0); idle(0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule